// File: doc/BRIEF.md
# Serial Control Port Register File

This block receives 16-bit command words over a three-wire serial link made of a bit clock, a data line and a latch strobe. All three lines come from outside the core clock domain, so they are synchronized into the core clock and their rising edges are found there. Data bits enter a shift register, most significant bit first. A strobe accepts the word only if exactly sixteen bits have been shifted since the previous strobe. An accepted word goes into one of four control registers, chosen by a two-bit address field.

Two registers hold the left and right attenuation codes. Each channel has a staged code and an active code. A write with the load bit clear updates only the staged copy. A write with the load bit set updates both copies, so a new gain can be prepared and then applied in one step. The other two registers hold the datapath settings: mute, de-emphasis, operation enable, word length, output mode, data format, word-clock polarity, attenuator control, system clock choice, rate selects and zero detection. Each setting drives its own output port.

Top module: `serial_ctl_regs`

## Requirements
- R1: Data is captured on each rising edge of `ser_clk`, most significant bit first. A rising edge of `ser_strobe` applies the word only if exactly 16 bits arrived since the previous strobe edge or since reset. A strobe after fewer or more bits is ignored. The bit count restarts at every strobe edge, whether or not the word was applied.
- R2: Word bits 10:9 select the register: 0 is left attenuation, 1 is right attenuation, 2 is datapath settings and 3 is format settings. Bits 15:11 have no effect.
- R3: At address 0, bits 7:0 are the left code. When bit 8 is 0, only `att_left_staged` takes the code and `att_left` keeps its value.
- R4: At address 0 with bit 8 set to 1, both `att_left_staged` and `att_left` take the code.
- R5: Address 1 has the same layout and staging rule for the right channel (`att_right_staged`, `att_right`). The left values are not affected.
- R6: At address 2, bit 0 drives `soft_mute`, bit 1 drives `deemph_en`, bit 2 drives `op_en`, bits 4:3 drive `word_len` and bits 8:5 drive `out_mode`.
- R7: At address 3, bit 0 drives `fmt_sel`, bit 1 drives `lr_polarity`, bit 2 drives `att_ctrl`, bit 3 drives `sysclk_sel`, bits 5:4 drive `dbl_rate`, bits 7:6 drive `rate_sel` and bit 8 drives `zero_det_en`.
- R8: After reset, all four attenuation codes are FFh (unity gain) and every other output is 0.
- R9: A write to one address leaves the outputs of the other three addresses unchanged. Outputs update within 8 core cycles of the strobe rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_strobe | input | 1 | Latch strobe; its rising edge applies the word |
| att_left | output | 8 | Active left attenuation code |
| att_left_staged | output | 8 | Staged left attenuation code |
| att_right | output | 8 | Active right attenuation code |
| att_right_staged | output | 8 | Staged right attenuation code |
| soft_mute | output | 1 | Soft mute request |
| deemph_en | output | 1 | De-emphasis enable |
| op_en | output | 1 | Operation enable |
| word_len | output | 2 | Input word length select |
| out_mode | output | 4 | Output mode select |
| fmt_sel | output | 1 | Audio data format select |
| lr_polarity | output | 1 | Word-clock polarity select |
| att_ctrl | output | 1 | Attenuator control |
| sysclk_sel | output | 1 | System clock select |
| dbl_rate | output | 2 | Double sampling rate select |
| rate_sel | output | 2 | Sampling rate select |
| zero_det_en | output | 1 | Infinite-zero detection enable |

## Verification
The assertions check on every cycle the properties that do not depend on the data values. The bit count stays within range and clears after each strobe edge. An active attenuation code changes only when a load write reaches its channel, and after that write it equals the staged copy. Each settings register keeps its value unless a write is addressed to it. The bench scenarios are needed for the rest: the field positions in each register, MSB-first order, the rejection of short and long words, the reset values, and the fact that reserved bits have no effect.

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs #(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] ATT_RESET = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_data,
  input  logic       ser_strobe,
  output logic [7:0] att_left,
  output logic [7:0] att_left_staged,
  output logic [7:0] att_right,
  output logic [7:0] att_right_staged,
  output logic       soft_mute,
  output logic       deemph_en,
  output logic       op_en,
  output logic [1:0] word_len,
  output logic [3:0] out_mode,
  output logic       fmt_sel,
  output logic       lr_polarity,
  output logic       att_ctrl,
  output logic       sysclk_sel,
  output logic [1:0] dbl_rate,
  output logic [1:0] rate_sel,
  output logic       zero_det_en
);
  localparam int WORD_W = 16;
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic [SYNC_STAGES-1:0] clk_q, dat_q, stb_q;
  logic                   clk_d, stb_d;
  logic [WORD_W-1:0]      shreg;
  logic [CNT_W-1:0]       cnt;
  logic [8:0]             cfg_a, cfg_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_q <= '0; dat_q <= '0; stb_q <= '0;
      clk_d <= 1'b0; stb_d <= 1'b0;
    end else begin
      clk_q <= {clk_q[SYNC_STAGES-2:0], ser_clk};
      dat_q <= {dat_q[SYNC_STAGES-2:0], ser_data};
      stb_q <= {stb_q[SYNC_STAGES-2:0], ser_strobe};
      clk_d <= clk_q[SYNC_STAGES-1];
      stb_d <= stb_q[SYNC_STAGES-1];
    end

  wire bit_rise = clk_q[SYNC_STAGES-1] & ~clk_d;
  wire stb_rise = stb_q[SYNC_STAGES-1] & ~stb_d;
  wire wr       = stb_rise && (cnt == FULL);
  wire [1:0] addr = shreg[10:9];
  wire load     = shreg[8];
  wire [7:0] code = shreg[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (stb_rise) begin
      cnt <= '0;
    end else if (bit_rise) begin
      shreg <= {shreg[WORD_W-2:0], dat_q[SYNC_STAGES-1]};
      if (cnt != OVER) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      att_left_staged <= ATT_RESET; att_left  <= ATT_RESET;
      att_right_staged <= ATT_RESET; att_right <= ATT_RESET;
      cfg_a <= '0; cfg_b <= '0;
    end else if (wr) begin
      case (addr)
        2'd0: begin
          att_left_staged <= code;
          if (load) att_left <= code;
        end
        2'd1: begin
          att_right_staged <= code;
          if (load) att_right <= code;
        end
        2'd2: cfg_a <= shreg[8:0];
        default: cfg_b <= shreg[8:0];
      endcase
    end

  assign soft_mute   = cfg_a[0];
  assign deemph_en   = cfg_a[1];
  assign op_en       = cfg_a[2];
  assign word_len    = cfg_a[4:3];
  assign out_mode    = cfg_a[8:5];
  assign fmt_sel     = cfg_b[0];
  assign lr_polarity = cfg_b[1];
  assign att_ctrl    = cfg_b[2];
  assign sysclk_sel  = cfg_b[3];
  assign dbl_rate    = cfg_b[5:4];
  assign rate_sel    = cfg_b[7:6];
  assign zero_det_en = cfg_b[8];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OVER); // R1
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> cnt == '0); // R1
  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd0 && load) |=> $stable(att_left)); // R3
  AST_LEFT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0 && load) |=> att_left == att_left_staged); // R4
  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd1 && load) |=> $stable(att_right)); // R5
  AST_RIGHT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd1 && load) |=> att_right == att_right_staged); // R5
  AST_CFG_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd2) |=> $stable({out_mode, word_len, op_en, deemph_en, soft_mute})); // R9
  AST_CFG_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 2'd3) |=> $stable({zero_det_en, rate_sel, dbl_rate, sysclk_sel,
                                       att_ctrl, lr_polarity, fmt_sel})); // R9
endmodule

// File: tb/serial_ctl_regs_test.sv
module serial_ctl_regs_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
  logic [7:0] att_left, att_left_staged, att_right, att_right_staged;
  logic soft_mute, deemph_en, op_en, fmt_sel, lr_polarity, att_ctrl, sysclk_sel, zero_det_en;
  logic [1:0] word_len, dbl_rate, rate_sel;
  logic [3:0] out_mode;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_ctl_regs uut (.*);

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = (i > 15) ? 1'b0 : w[i];
      idle(4); ser_clk = 1'b1;
      idle(4); ser_clk = 1'b0;
    end
    idle(4); ser_strobe = 1'b1;
    idle(4); ser_strobe = 1'b0;
    idle(8);
  endtask

  function automatic logic [15:0] mk(input logic [1:0] a, input logic [8:0] p);
    return {5'b0, a, p};
  endfunction

  logic [8:0] cfg2, cfg3;
  always_comb cfg2 = {out_mode, word_len, op_en, deemph_en, soft_mute};
  always_comb cfg3 = {zero_det_en, rate_sel, dbl_rate, sysclk_sel, att_ctrl, lr_polarity, fmt_sel};

  task automatic t_reset;
    check("R8 att_left", att_left, 8'hFF);
    check("R8 att_left_staged", att_left_staged, 8'hFF);
    check("R8 att_right", att_right, 8'hFF);
    check("R8 att_right_staged", att_right_staged, 8'hFF);
    check("R8 cfg2", cfg2, 0);
    check("R8 cfg3", cfg3, 0);
  endtask

  task automatic t_left_stage_commit;
    send(mk(2'd0, {1'b0, 8'h40}), 16);
    check("R3 staged left", att_left_staged, 8'h40);
    check("R3 active left held", att_left, 8'hFF);
    send(mk(2'd0, {1'b1, 8'h21}), 16);
    check("R4 active left", att_left, 8'h21);
    check("R4 staged left", att_left_staged, 8'h21);
    check("R5 right untouched", att_right, 8'hFF);
  endtask

  task automatic t_right;
    send(mk(2'd1, {1'b0, 8'h9C}), 16);
    check("R5 staged right", att_right_staged, 8'h9C);
    check("R5 active right held", att_right, 8'hFF);
    send(mk(2'd1, {1'b1, 8'h00}), 16);
    check("R5 active right", att_right, 8'h00);
    check("R5 left untouched", att_left, 8'h21);
  endtask

  task automatic t_cfg;
    send(mk(2'd2, {4'b1010, 2'b01, 1'b1, 1'b0, 1'b1}), 16);
    check("R6 soft_mute", soft_mute, 1);
    check("R6 deemph_en", deemph_en, 0);
    check("R6 op_en", op_en, 1);
    check("R6 word_len", word_len, 2'b01);
    check("R6 out_mode", out_mode, 4'b1010);
    check("R9 cfg3 untouched", cfg3, 0);
    send(mk(2'd3, {1'b1, 2'b10, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0}), 16);
    check("R7 fmt_sel", fmt_sel, 0);
    check("R7 lr_polarity", lr_polarity, 1);
    check("R7 att_ctrl", att_ctrl, 0);
    check("R7 sysclk_sel", sysclk_sel, 1);
    check("R7 dbl_rate", dbl_rate, 2'b01);
    check("R7 rate_sel", rate_sel, 2'b10);
    check("R7 zero_det_en", zero_det_en, 1);
    check("R9 cfg2 untouched", cfg2, 9'b1010_01_1_0_1);
    check("R9 left untouched", att_left, 8'h21);
  endtask

  task automatic t_bad_length;
    send(mk(2'd2, 9'h1FF), 15);
    check("R1 short word ignored", cfg2, 9'b1010_01_1_0_1);
    send(mk(2'd2, 9'h1FF), 17);
    check("R1 long word ignored", cfg2, 9'b1010_01_1_0_1);
    send(mk(2'd2, 9'h0C2), 16);
    check("R1 count restarted", cfg2, 9'h0C2);
  endtask

  task automatic t_reserved;
    send({5'b10101, 2'd0, 1'b1, 8'h5A}, 16);
    check("R2 reserved ignored", att_left, 8'h5A);
    check("R2 addr kept cfg3", cfg3, {1'b1, 2'b10, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0});
    send({5'b11111, 2'd1, 1'b1, 8'h81}, 16);
    check("R2 reserved ignored right", att_right, 8'h81);
    check("R2 left untouched", att_left, 8'h5A);
  endtask

  task automatic t_msb_first;
    send(mk(2'd0, {1'b1, 8'h01}), 16);
    check("R1 msb first", att_left, 8'h01);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(3);
    t_reset;
    t_left_stage_commit;
    t_right;
    t_cfg;
    t_bad_length;
    t_reserved;
    t_msb_first;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule